// File: doc/BRIEF.md
# Ethernet Transmit Link Fault Controller

This block sits on the transmit side of a reconciliation sublayer driving a 64-bit, eight-lane XGMII-style column interface. On every clock it decides what goes out toward the PCS: the MAC client column unchanged, a column of idle characters, or a remote fault ordered-set column. The decision depends on a four-bit fault configuration value and on the local fault and remote fault status flags reported by the receive side.

Configuration bit 0 enables transmit fault signaling. Bit 3 forces remote fault. Bit 1 chooses unidirectional (set) or bidirectional (clear) operation. Bit 2, in unidirectional operation, selects a backward-compatible mode that never sends remote fault. Changes in status or configuration are registered, so they act from the next column. A packet is always handled as a whole, at its start column. A packet that has begun is forwarded to its end. A packet whose start column was suppressed stays suppressed to its last column. This way a truncated frame never reaches the PCS.

The policy decode registers one of four policies: pass, idle, remote fault, or unidirectional-local-fault. A packet state machine tracks column position with four states:
- `S_GAP`: an inter-packet column.
- `S_POST`: the first gap column after a forwarded end of packet.
- `S_FWD`: inside a forwarded packet.
- `S_DROP`: inside a suppressed packet.

Its transitions:
- GAP/POST → FWD on a start column accepted under the pass or unidirectional policy.
- GAP/POST → POST on a single-column packet that is accepted.
- GAP/POST → DROP on a start column under the idle or remote fault policy.
- GAP/POST → GAP on a suppressed single-column packet, and on any column without a start.
- FWD → POST on end of packet.
- DROP → GAP on end of packet.

Top module: `tx_fault_ctrl`

## Requirements
- R1: With cfg bit 0 clear, the output is never a remote fault column; columns outside a suppressed packet are passed unchanged (status 0) whatever the fault flags are.
- R2: With cfg bits 0 and 3 set, every column after the current packet is a remote fault column, and new packets are not forwarded.
- R3: Unidirectional mode (bit 1 set) with bit 2 set passes all columns unchanged and sends no remote fault, whatever the fault flags are.
- R4: Unidirectional mode with bit 2 clear and local fault present forwards packets unchanged. The column after a forwarded end-of-packet column is an idle column, and each following gap column is a remote fault column until the next packet starts.
- R5: Unidirectional mode with bit 2 clear and only a remote fault, or no fault, passes all columns unchanged.
- R6: Bidirectional mode (bit 1 clear) with local fault present replaces every column outside a forwarded packet with remote fault columns.
- R7: Bidirectional mode with only a remote fault replaces every column outside a forwarded packet with idle columns.
- R8: Bidirectional mode with no fault passes all columns unchanged.
- R9: When local and remote fault are both reported, local fault decides the behaviour.
- R10: A packet forwarded at its start column is forwarded to its end-of-packet column even if the policy changes. A packet suppressed at its start column has no column passed until its end.
- R11: Lane i is txd[8i+7:8i] with control bit txc[i]. An idle column is 0x07 in all lanes with txc = 0xFF. A remote fault column is 0x9C (control) in lanes 0 and 4, 0x00 in lanes 1, 2, 5 and 6, and 0x02 in lanes 3 and 7, with txc = 0x11.
- R12: The PCS column is registered one clock after the MAC column it replaces. tx_mode reports that column as 0 = passed MAC data, 1 = idle substituted, 2 = remote fault substituted, and never takes the value 3.
- R13: link_status equals {rf_stat, lf_stat} of the previous clock, whatever the configuration.
- R14: During reset the output is an idle column, tx_mode is 1 and link_status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 4 | Fault configuration: [0] enable, [1] unidirectional, [2] backward compatible, [3] force remote fault |
| lf_stat | input | 1 | Local fault present (receive side) |
| rf_stat | input | 1 | Remote fault present (receive side) |
| mac_txd | input | 64 | MAC transmit column data |
| mac_txc | input | 8 | MAC transmit column control bits |
| mac_sop | input | 1 | Column holds a start of packet |
| mac_eop | input | 1 | Column holds an end of packet |
| pcs_txd | output | 64 | Column data toward the PCS |
| pcs_txc | output | 8 | Column control bits toward the PCS |
| tx_mode | output | 2 | Content of the current output column |
| link_status | output | 2 | Registered {remote fault, local fault} |

## Verification
On every cycle the assertions check three things. The column content matches the reported tx_mode, a passed column equals the MAC column of the previous clock, and link_status follows the fault flags. They also check that no remote fault column appears while signaling has been disabled for two clocks. Which policy each combination of the configuration and fault flags selects can only be shown by the bench's sweep over all 64 combinations, as can the single idle column that precedes remote fault in unidirectional mode. Packet-boundary behaviour likewise needs directed scenarios: a fault appearing or clearing in the middle of a packet.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    // Registered transmit policy derived from configuration and fault flags
    typedef enum logic [1:0] {
        POL_PASS = 2'd0,
        POL_IDLE = 2'd1,
        POL_RF   = 2'd2,
        POL_UNI  = 2'd3
    } policy_e;

    // Content of one output column
    typedef enum logic [1:0] {
        MODE_DATA = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_RF   = 2'd2
    } txmode_e;

    // Column position relative to packets
    typedef enum logic [1:0] {
        S_GAP  = 2'd0,
        S_POST = 2'd1,
        S_FWD  = 2'd2,
        S_DROP = 2'd3
    } pkt_state_e;

    localparam logic [7:0] IDLE_BYTE = 8'h07;
    localparam logic [7:0] SEQ_BYTE  = 8'h9C;
    localparam logic [7:0] RF_CODE   = 8'h02;
    localparam int         GRP_LANES = 4;

    // Byte of the remote fault ordered set for a given lane
    function automatic logic [7:0] rf_byte(input int lane);
        int pos;
        pos = lane % GRP_LANES;
        if (pos == 0)                  return SEQ_BYTE;
        else if (pos == GRP_LANES - 1) return RF_CODE;
        else                           return 8'h00;
    endfunction

    // Control bit of the remote fault ordered set for a given lane
    function automatic logic rf_ctl(input int lane);
        return (lane % GRP_LANES) == 0;
    endfunction

endpackage

// File: rtl/tfc_policy.sv
module tfc_policy
    import tfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cfg,
    input  logic          lf_stat,
    input  logic          rf_stat,
    output policy_e       pol_q,
    output logic [1:0]    link_q
);

    localparam int B_EN    = 0;
    localparam int B_UNI   = 1;
    localparam int B_COMPAT = 2;
    localparam int B_FORCE = 3;

    policy_e pol_d;

    always_comb begin
        pol_d = POL_PASS;
        if (!cfg[B_EN]) begin
            pol_d = POL_PASS;
        end else if (cfg[B_FORCE]) begin
            pol_d = POL_RF;
        end else if (cfg[B_UNI]) begin
            if (!cfg[B_COMPAT] && lf_stat) pol_d = POL_UNI;
            else                           pol_d = POL_PASS;
        end else begin
            // local fault wins over remote fault
            if (lf_stat)      pol_d = POL_RF;
            else if (rf_stat) pol_d = POL_IDLE;
            else              pol_d = POL_PASS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= POL_PASS;
            link_q <= 2'b00;
        end else begin
            pol_q  <= pol_d;
            link_q <= {rf_stat, lf_stat};
        end
    end

endmodule

// File: rtl/tfc_pkt_fsm.sv
module tfc_pkt_fsm
    import tfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  policy_e  pol,
    input  logic     sop,
    input  logic     eop,
    output txmode_e  col_mode
);

    pkt_state_e state_q;
    pkt_state_e state_d;
    logic       fwd_ok;
    txmode_e    fill;

    assign fwd_ok = (pol == POL_PASS) || (pol == POL_UNI);
    assign fill   = (pol == POL_RF) ? MODE_RF : MODE_IDLE;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_GAP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FWD:  state_d = eop ? S_POST : S_FWD;
            S_DROP: state_d = eop ? S_GAP : S_DROP;
            S_GAP, S_POST: begin
                if (sop) begin
                    if (fwd_ok) state_d = eop ? S_POST : S_FWD;
                    else        state_d = eop ? S_GAP : S_DROP;
                end else begin
                    state_d = S_GAP;
                end
            end
        endcase
    end

    // column content for the current MAC column
    always_comb begin
        col_mode = MODE_DATA;
        unique case (state_q)
            S_FWD:  col_mode = MODE_DATA;
            S_DROP: col_mode = fill;
            S_GAP, S_POST: begin
                if (sop) begin
                    col_mode = fwd_ok ? MODE_DATA : fill;
                end else begin
                    unique case (pol)
                        POL_PASS: col_mode = MODE_DATA;
                        POL_IDLE: col_mode = MODE_IDLE;
                        POL_RF:   col_mode = MODE_RF;
                        POL_UNI:  col_mode = (state_q == S_POST) ? MODE_IDLE : MODE_RF;
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/tfc_col_mux.sv
module tfc_col_mux
    import tfc_pkg::*;
#(
    parameter int LANES = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  txmode_e            col_mode,
    input  logic [8*LANES-1:0] mac_txd,
    input  logic [LANES-1:0]   mac_txc,
    output logic [8*LANES-1:0] pcs_txd,
    output logic [LANES-1:0]   pcs_txc,
    output logic [1:0]         mode_q
);

    localparam int DW = 8 * LANES;

    logic [DW-1:0]    idle_d;
    logic [LANES-1:0] idle_c;
    logic [DW-1:0]    rf_d;
    logic [LANES-1:0] rf_c;
    logic [DW-1:0]    nxt_d;
    logic [LANES-1:0] nxt_c;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign idle_d[8*ln +: 8] = IDLE_BYTE;
        assign idle_c[ln]        = 1'b1;
        assign rf_d[8*ln +: 8]   = rf_byte(ln);
        assign rf_c[ln]          = rf_ctl(ln);
    end

    always_comb begin
        nxt_d = mac_txd;
        nxt_c = mac_txc;
        unique case (col_mode)
            MODE_DATA: begin nxt_d = mac_txd; nxt_c = mac_txc; end
            MODE_IDLE: begin nxt_d = idle_d;  nxt_c = idle_c;  end
            MODE_RF:   begin nxt_d = rf_d;    nxt_c = rf_c;    end
            default:   begin nxt_d = idle_d;  nxt_c = idle_c;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcs_txd <= idle_d;
            pcs_txc <= idle_c;
            mode_q  <= MODE_IDLE;
        end else begin
            pcs_txd <= nxt_d;
            pcs_txc <= nxt_c;
            mode_q  <= col_mode;
        end
    end

endmodule

// File: rtl/tx_fault_ctrl.sv
module tx_fault_ctrl
    import tfc_pkg::*;
#(
    parameter int LANES = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cfg,
    input  logic               lf_stat,
    input  logic               rf_stat,
    input  logic [8*LANES-1:0] mac_txd,
    input  logic [LANES-1:0]   mac_txc,
    input  logic               mac_sop,
    input  logic               mac_eop,
    output logic [8*LANES-1:0] pcs_txd,
    output logic [LANES-1:0]   pcs_txc,
    output logic [1:0]         tx_mode,
    output logic [1:0]         link_status
);

    policy_e pol_q;
    txmode_e col_mode;

    tfc_policy u_policy (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .lf_stat (lf_stat),
        .rf_stat (rf_stat),
        .pol_q   (pol_q),
        .link_q  (link_status)
    );

    tfc_pkt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol      (pol_q),
        .sop      (mac_sop),
        .eop      (mac_eop),
        .col_mode (col_mode)
    );

    tfc_col_mux #(.LANES(LANES)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_mode (col_mode),
        .mac_txd  (mac_txd),
        .mac_txc  (mac_txc),
        .pcs_txd  (pcs_txd),
        .pcs_txc  (pcs_txc),
        .mode_q   (tx_mode)
    );

endmodule

// File: rtl/tfc_chk.sv
module tfc_chk
    import tfc_pkg::*;
#(
    parameter int LANES = 8
)(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic               lf_stat,
    input logic               rf_stat,
    input logic [8*LANES-1:0] mac_txd,
    input logic [LANES-1:0]   mac_txc,
    input logic [8*LANES-1:0] pcs_txd,
    input logic [LANES-1:0]   pcs_txc,
    input logic [1:0]         tx_mode,
    input logic [1:0]         link_status
);

    logic [8*LANES-1:0] exp_rf_d;
    logic [LANES-1:0]   exp_rf_c;
    logic [1:0]         age;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_ref
        assign exp_rf_d[8*ln +: 8] = rf_byte(ln);
        assign exp_rf_c[ln]        = rf_ctl(ln);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        age <= 2'd0;
        else if (age != 3) age <= age + 2'd1;
    end

    // R11
    rf_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd2) |-> (pcs_txd == exp_rf_d && pcs_txc == exp_rf_c));

    // R11
    idle_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd1) |-> (pcs_txd == {LANES{IDLE_BYTE}} && pcs_txc == {LANES{1'b1}}));

    // R12
    mode_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mode != 2'd3);

    // R12
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && tx_mode == 2'd0) |->
            (pcs_txd == $past(mac_txd) && pcs_txc == $past(mac_txc)));

    // R1
    no_rf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && !$past(cfg_en) && !$past(cfg_en, 2)) |-> tx_mode != 2'd2);

    // R13
    link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1) |-> link_status == $past({rf_stat, lf_stat}));

endmodule

bind tx_fault_ctrl tfc_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg[0]),
    .lf_stat     (lf_stat),
    .rf_stat     (rf_stat),
    .mac_txd     (mac_txd),
    .mac_txc     (mac_txc),
    .pcs_txd     (pcs_txd),
    .pcs_txc     (pcs_txc),
    .tx_mode     (tx_mode),
    .link_status (link_status)
);

// File: tb/test_tx_fault_ctrl.sv
module test_tx_fault_ctrl;

    localparam logic [63:0] IDLE_D = {8{8'h07}};
    localparam logic [7:0]  IDLE_C = 8'hFF;
    localparam logic [63:0] RF_D   = 64'h0200009C_0200009C;
    localparam logic [7:0]  RF_C   = 8'h11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg = 4'd0;
    logic        lf_stat = 1'b0;
    logic        rf_stat = 1'b0;
    logic [63:0] mac_txd = IDLE_D;
    logic [7:0]  mac_txc = IDLE_C;
    logic        mac_sop = 1'b0;
    logic        mac_eop = 1'b0;
    logic [63:0] pcs_txd;
    logic [7:0]  pcs_txc;
    logic [1:0]  tx_mode;
    logic [1:0]  link_status;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tx_fault_ctrl i_tx_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .lf_stat(lf_stat), .rf_stat(rf_stat),
        .mac_txd(mac_txd), .mac_txc(mac_txc), .mac_sop(mac_sop), .mac_eop(mac_eop),
        .pcs_txd(pcs_txd), .pcs_txc(pcs_txc), .tx_mode(tx_mode), .link_status(link_status)
    );

    // expected policy: 0 pass, 1 idle, 2 remote fault, 3 unidirectional local fault
    function automatic int exp_pol(input logic [3:0] c, input logic lf, input logic rf);
        if (!c[0])     return 0;
        if (c[3])      return 2;
        if (c[1])      return (!c[2] && lf) ? 3 : 0;
        if (lf)        return 2;
        if (rf)        return 1;
        return 0;
    endfunction

    function automatic string req_of(input logic [3:0] c, input logic lf, input logic rf);
        if (!c[0]) return "R1";
        if (c[3])  return "R2";
        if (c[1]) begin
            if (c[2]) return "R3";
            if (lf)   return "R4";
            return "R5";
        end
        if (lf && rf) return "R9";
        if (lf)       return "R6";
        if (rf)       return "R7";
        return "R8";
    endfunction

    // drive one MAC column, advance to the next falling edge
    task automatic put_col(input logic [63:0] d, input logic [7:0] c, input logic s, input logic e);
        mac_txd = d; mac_txc = c; mac_sop = s; mac_eop = e;
        @(negedge clk);
    endtask

    // check the output column against an expected mode (R11, R12)
    task automatic chk_col(input string req, input int em, input logic [63:0] md, input logic [7:0] mc);
        logic [63:0] ed;
        logic [7:0]  ec;
        ed = (em == 0) ? md : (em == 1) ? IDLE_D : RF_D;
        ec = (em == 0) ? mc : (em == 1) ? IDLE_C : RF_C;
        n_run++;
        if (tx_mode != em[1:0] || pcs_txd != ed || pcs_txc != ec) begin
            n_fail++;
            $display("FAIL %s: mode=%0d txd=%h txc=%h expected mode=%0d txd=%h txc=%h",
                     req, tx_mode, pcs_txd, pcs_txc, em, ed, ec);
        end
    endtask

    task automatic chk_not_data(input string req);
        n_run++;
        if (tx_mode == 2'd0) begin
            n_fail++;
            $display("FAIL %s: mode=%0d expected a substituted column (mode 1 or 2)", req, tx_mode);
        end
    endtask

    function automatic logic [63:0] pkt_d(input int k);
        return {8{8'(8'h10 + k)}} ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    initial begin
        #(20 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] sd, d1, d2, ed;
        repeat (3) @(negedge clk);
        // R14 reset state
        n_run++;
        if (pcs_txd != IDLE_D || pcs_txc != IDLE_C || tx_mode != 2'd1 || link_status != 2'd0) begin
            n_fail++;
            $display("FAIL R14: txd=%h txc=%h mode=%0d link=%0d expected txd=%h txc=%h mode=1 link=0",
                     pcs_txd, pcs_txc, tx_mode, link_status, IDLE_D, IDLE_C);
        end
        rst_n = 1'b1;
        @(negedge clk);

        sd = {pkt_d(0)[63:8], 8'hFB};
        d1 = pkt_d(1);
        d2 = pkt_d(2);
        ed = {24'h070707, 8'hFD, pkt_d(3)[31:0]};

        // sweep of all configurations and fault flag combinations
        for (int cv = 0; cv < 16; cv++) begin
            for (int sv = 0; sv < 4; sv++) begin
                int    p;
                string rq;
                cfg = 4'(cv); lf_stat = sv[0]; rf_stat = sv[1];
                p  = exp_pol(cfg, lf_stat, rf_stat);
                rq = req_of(cfg, lf_stat, rf_stat);
                repeat (3) put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
                // R13 status reported regardless of cfg
                n_run++;
                if (link_status != {rf_stat, lf_stat}) begin
                    n_fail++;
                    $display("FAIL R13: link=%0d expected %0d", link_status, {rf_stat, lf_stat});
                end
                put_col(sd, 8'h01, 1'b1, 1'b0);
                chk_col(rq, (p == 0 || p == 3) ? 0 : p, sd, 8'h01);
                put_col(d1, 8'h00, 1'b0, 1'b0);
                chk_col(rq, (p == 0 || p == 3) ? 0 : p, d1, 8'h00);
                put_col(d2, 8'h00, 1'b0, 1'b0);
                chk_col(rq, (p == 0 || p == 3) ? 0 : p, d2, 8'h00);
                put_col(ed, 8'hF0, 1'b0, 1'b1);
                chk_col(rq, (p == 0 || p == 3) ? 0 : p, ed, 8'hF0);
                for (int g = 0; g < 3; g++) begin
                    int em;
                    if (p == 3) em = (g == 0) ? 1 : 2;   // R4 one idle then RF
                    else        em = p;
                    put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
                    chk_col(rq, em, IDLE_D, IDLE_C);
                end
            end
        end

        // R10: local fault appears inside a forwarded packet (bidirectional)
        cfg = 4'b0001; lf_stat = 1'b0; rf_stat = 1'b0;
        repeat (3) put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        put_col(sd, 8'h01, 1'b1, 1'b0);
        chk_col("R10", 0, sd, 8'h01);
        lf_stat = 1'b1;
        put_col(d1, 8'h00, 1'b0, 1'b0);
        chk_col("R10", 0, d1, 8'h00);
        put_col(d2, 8'h00, 1'b0, 1'b0);
        chk_col("R10", 0, d2, 8'h00);
        put_col(ed, 8'hF0, 1'b0, 1'b1);
        chk_col("R10", 0, ed, 8'hF0);
        put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        chk_col("R10", 2, IDLE_D, IDLE_C);
        put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        chk_col("R10", 2, IDLE_D, IDLE_C);

        // R10: fault clears inside a suppressed packet
        repeat (2) put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        put_col(sd, 8'h01, 1'b1, 1'b0);
        chk_col("R10", 2, sd, 8'h01);
        lf_stat = 1'b0;
        put_col(d1, 8'h00, 1'b0, 1'b0);
        chk_not_data("R10");
        put_col(d2, 8'h00, 1'b0, 1'b0);
        chk_not_data("R10");
        put_col(ed, 8'hF0, 1'b0, 1'b1);
        chk_not_data("R10");
        put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        chk_col("R10", 0, IDLE_D, IDLE_C);

        // R4: back-to-back packets in unidirectional local fault mode
        cfg = 4'b0011; lf_stat = 1'b1;
        repeat (3) put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        chk_col("R4", 2, IDLE_D, IDLE_C);
        put_col(sd, 8'h01, 1'b1, 1'b0);
        chk_col("R4", 0, sd, 8'h01);
        put_col(ed, 8'hF0, 1'b0, 1'b1);
        chk_col("R4", 0, ed, 8'hF0);
        put_col(IDLE_D, IDLE_C, 1'b0, 1'b0);
        chk_col("R4", 1, IDLE_D, IDLE_C);
        put_col(sd, 8'h01, 1'b1, 1'b0);
        chk_col("R4", 0, sd, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule